// File: doc/BRIEF.md
# Floating-Point Compare Flag Unit

This block compares two single-precision IEEE operands and turns the outcome into four integer-style condition flags: less-than, equal, greater-or-equal and unordered. These are the N, Z, C and V flags that a following conditional instruction consumes. The second operand is measured against the first. So "less than" means operand B is below operand A. A negate control flips the sign of operand A before the comparison, which lets the unit test B against -A.

The unit has two compare forms. The quiet form is meant for equality and unordered tests. It stays silent when a quiet NaN is involved. The signalling form is meant for relational tests. It raises an invalid-operation pulse whenever the result is unordered. A signalling NaN raises invalid-operation in either form. A separate control bit changes the meaning of C so that C is also set for an unordered result. The comparison itself is combinational. The flags and the exception pulse are captured on a valid strobe.

Top module: `fpcmp_nzcv`

## Requirements
- R1: While `rst_n` is low, `flags_o` is 4'b0000 and both `flags_vld_o` and `inv_exc_o` are 0.
- R2: `flags_o` is updated at the first rising clock edge at which `valid_i` is high, and `flags_vld_o` is high for the cycle that follows. While `valid_i` is low, operand and control changes leave `flags_o` unchanged and `flags_vld_o` low.
- R3: The flags are packed as `flags_o[3]`=N, `[2]`=Z, `[1]`=C, `[0]`=V. For ordered operands the outputs are as follows:
  - B < A gives 4'b1000.
  - B == A gives 4'b0110.
  - B > A gives 4'b0010.
- R4: An operand is a NaN when its exponent field (bits 30:23) is all ones and its fraction (bits 22:0) is nonzero. If either operand is a NaN and `alt_c_i` is 0, the result is unordered and `flags_o` is 4'b0001.
- R5: With `alt_c_i` = 1, an unordered result gives 4'b0011. `alt_c_i` has no effect on ordered results.
- R6: Positive zero (0x00000000) and negative zero (0x80000000) compare equal in either order.
- R7: With `negate_i` = 1, operand B is compared against operand A with its sign bit (bit 31) inverted. A NaN stays a NaN when it is negated.
- R8: With `signal_i` = 1 (signalling form), an unordered result sets `inv_exc_o` in the cycle after the strobe.
- R9: With `signal_i` = 0 (quiet form), a compare involving only quiet NaNs (fraction bit 22 set) raises no `inv_exc_o`.
- R10: A signalling NaN (fraction bit 22 clear, fraction nonzero) in either operand sets `inv_exc_o` in both forms.
- R11: `inv_exc_o` lasts exactly one cycle per strobe. It stays low for ordered compares and in cycles not preceded by a strobe.
- R12: Infinities (exponent all ones, fraction zero) are ordered values:
  - Equal infinities compare equal.
  - -inf is below every finite value.
  - +inf is above every finite value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Compare strobe |
| op_a_i | input | 32 | Operand A (reference operand) |
| op_b_i | input | 32 | Operand B (compared against A) |
| negate_i | input | 1 | Compare B against -A |
| signal_i | input | 1 | 1 = signalling form, 0 = quiet form |
| alt_c_i | input | 1 | Set C also for unordered results |
| flags_o | output | 4 | Registered {N,Z,C,V} |
| flags_vld_o | output | 1 | High the cycle after a strobe |
| inv_exc_o | output | 1 | Invalid-operation pulse |

## Verification
All results come from one register stage. For a strobe sampled at clock edge k, `flags_o`, `flags_vld_o` and `inv_exc_o` take their new values at edge k. They are checked at the falling edge after it. The bench drives inputs on falling edges and lowers the strobe before that check. The check then looks again one cycle later to confirm that the exception and valid pulses have ended while the flags hold. In the hold test, operands are changed with the strobe low and sampled after two further edges, which shows the captured flags did not move.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;

  // Relation of operand B to operand A after optional negation.
  typedef enum logic [1:0] {
    ORD_LT = 2'd0,
    ORD_EQ = 2'd1,
    ORD_GT = 2'd2,
    ORD_UN = 2'd3
  } ord_e;

  // Condition flag bundle; n is the most significant bit when flattened.
  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;

endpackage

// File: rtl/fpcmp_classify.sv
module fpcmp_classify #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int W = 1 + EXP_W + MAN_W
) (
  input  logic [W-1:0] val_i,
  output logic         is_nan_o,
  output logic         is_snan_o,
  output logic         is_zero_o,
  output logic [W-1:0] key_o
);

  logic exp_ones;
  logic frac_nz;

  always_comb begin
    exp_ones  = &val_i[W-2:MAN_W];
    frac_nz   = |val_i[MAN_W-1:0];
    is_nan_o  = exp_ones & frac_nz;
    // Quiet bit is the fraction MSB; a clear quiet bit marks a signalling NaN.
    is_snan_o = exp_ones & frac_nz & ~val_i[MAN_W-1];
    is_zero_o = ~|val_i[W-2:0];
    // Map sign-magnitude onto an unsigned key that sorts like the real value.
    if (val_i[W-1]) key_o = ~val_i;
    else            key_o = {1'b1, val_i[W-2:0]};
  end

endmodule

// File: rtl/fpcmp_order.sv
module fpcmp_order #(
  parameter int W = 32
) (
  input  logic           nan_a_i,
  input  logic           nan_b_i,
  input  logic           zero_a_i,
  input  logic           zero_b_i,
  input  logic [W-1:0]   key_a_i,
  input  logic [W-1:0]   key_b_i,
  output fpcmp_pkg::ord_e ord_o
);
  import fpcmp_pkg::*;

  always_comb begin
    if (nan_a_i || nan_b_i)        ord_o = ORD_UN;
    else if (zero_a_i && zero_b_i) ord_o = ORD_EQ;
    else if (key_b_i < key_a_i)    ord_o = ORD_LT;
    else if (key_b_i == key_a_i)   ord_o = ORD_EQ;
    else                           ord_o = ORD_GT;
  end

endmodule

// File: rtl/fpcmp_flag_map.sv
module fpcmp_flag_map (
  input  fpcmp_pkg::ord_e  ord_i,
  input  logic             alt_c_i,
  input  logic             signal_i,
  input  logic             snan_any_i,
  output fpcmp_pkg::nzcv_t flags_o,
  output logic             inv_o
);
  import fpcmp_pkg::*;

  always_comb begin
    flags_o = '0;
    unique case (ord_i)
      ORD_LT: flags_o.n = 1'b1;
      ORD_EQ: begin
        flags_o.z = 1'b1;
        flags_o.c = 1'b1;
      end
      ORD_GT: flags_o.c = 1'b1;
      ORD_UN: begin
        flags_o.v = 1'b1;
        flags_o.c = alt_c_i;
      end
      default: flags_o = '0;
    endcase
    inv_o = snan_any_i | (signal_i & (ord_i == ORD_UN));
  end

endmodule

// File: rtl/fpcmp_nzcv.sv
module fpcmp_nzcv #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int W = 1 + EXP_W + MAN_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         valid_i,
  input  logic [W-1:0] op_a_i,
  input  logic [W-1:0] op_b_i,
  input  logic         negate_i,
  input  logic         signal_i,
  input  logic         alt_c_i,
  output logic [3:0]   flags_o,
  output logic         flags_vld_o,
  output logic         inv_exc_o
);
  import fpcmp_pkg::*;

  localparam int NOPS = 2;

  logic [W-1:0]    opnd  [NOPS];
  logic [W-1:0]    key_v [NOPS];
  logic [NOPS-1:0] nan_v;
  logic [NOPS-1:0] snan_v;
  logic [NOPS-1:0] zero_v;

  ord_e  ord_cmb;
  nzcv_t flags_cmb;
  logic  inv_cmb;

  nzcv_t flags_d, flags_q;
  logic  vld_d, vld_q;
  logic  exc_d, exc_q;

  // Operand A may be sign-flipped; NaN-ness is unaffected by the sign.
  assign opnd[0] = {op_a_i[W-1] ^ negate_i, op_a_i[W-2:0]};
  assign opnd[1] = op_b_i;

  for (genvar g = 0; g < NOPS; g++) begin : g_cls
    fpcmp_classify #(
      .EXP_W(EXP_W),
      .MAN_W(MAN_W)
    ) u_cls (
      .val_i    (opnd[g]),
      .is_nan_o (nan_v[g]),
      .is_snan_o(snan_v[g]),
      .is_zero_o(zero_v[g]),
      .key_o    (key_v[g])
    );
  end

  fpcmp_order #(
    .W(W)
  ) u_order (
    .nan_a_i (nan_v[0]),
    .nan_b_i (nan_v[1]),
    .zero_a_i(zero_v[0]),
    .zero_b_i(zero_v[1]),
    .key_a_i (key_v[0]),
    .key_b_i (key_v[1]),
    .ord_o   (ord_cmb)
  );

  fpcmp_flag_map u_map (
    .ord_i     (ord_cmb),
    .alt_c_i   (alt_c_i),
    .signal_i  (signal_i),
    .snan_any_i(|snan_v),
    .flags_o   (flags_cmb),
    .inv_o     (inv_cmb)
  );

  // Next-state: flags load only on the strobe, pulses follow the strobe.
  always_comb begin
    flags_d = flags_q;
    if (valid_i) flags_d = flags_cmb;
    vld_d = valid_i;
    exc_d = valid_i & inv_cmb;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      vld_q   <= 1'b0;
      exc_q   <= 1'b0;
    end else begin
      flags_q <= flags_d;
      vld_q   <= vld_d;
      exc_q   <= exc_d;
    end
  end

  assign flags_o     = flags_q;
  assign flags_vld_o = vld_q;
  assign inv_exc_o   = exc_q;

endmodule

// File: rtl/fpcmp_nzcv_chk.sv
module fpcmp_nzcv_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       valid_i,
  input logic       signal_i,
  input logic       alt_c_i,
  input logic [3:0] flags_o,
  input logic       flags_vld_o,
  input logic       inv_exc_o
);

  always @(negedge clk) begin
    if (!rst_n) begin
      p_reset_clear_r1: assert (flags_o == 4'b0000 && !flags_vld_o && !inv_exc_o)
        else $error("R1 outputs not cleared in reset");
    end
  end

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> $stable(flags_o));

  p_vld_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i |=> flags_vld_o);

  p_vld_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> !flags_vld_o);

  p_ordered_shape_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_vld_o && !flags_o[0]) |-> ((flags_o[3] != flags_o[1]) && (!flags_o[2] || flags_o[1])));

  p_unord_nz_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_vld_o && flags_o[0]) |-> (!flags_o[3] && !flags_o[2]));

  p_alt_c_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && alt_c_i) |=> (!flags_o[0] || flags_o[1]));

  p_alt_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && !alt_c_i) |=> (!flags_o[0] || !flags_o[1]));

  p_signal_unord_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && signal_i) |=> (inv_exc_o == flags_o[0]));

  p_quiet_exc_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && !signal_i) |=> (!inv_exc_o || flags_o[0]));

  p_exc_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> !inv_exc_o);

endmodule

bind fpcmp_nzcv fpcmp_nzcv_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .valid_i    (valid_i),
  .signal_i   (signal_i),
  .alt_c_i    (alt_c_i),
  .flags_o    (flags_o),
  .flags_vld_o(flags_vld_o),
  .inv_exc_o  (inv_exc_o)
);

// File: tb/fpcmp_nzcv_tb_top.sv
module fpcmp_nzcv_tb_top;

  localparam logic [31:0] P_ONE  = 32'h3F80_0000;
  localparam logic [31:0] P_TWO  = 32'h4000_0000;
  localparam logic [31:0] M_ONE  = 32'hBF80_0000;
  localparam logic [31:0] M_TWO  = 32'hC000_0000;
  localparam logic [31:0] P_ZERO = 32'h0000_0000;
  localparam logic [31:0] M_ZERO = 32'h8000_0000;
  localparam logic [31:0] P_INF  = 32'h7F80_0000;
  localparam logic [31:0] M_INF  = 32'hFF80_0000;
  localparam logic [31:0] P_MAX  = 32'h7F7F_FFFF;
  localparam logic [31:0] DENORM = 32'h0000_0001;
  localparam logic [31:0] QNAN   = 32'h7FC0_0000;
  localparam logic [31:0] SNAN   = 32'h7F80_0001;

  localparam logic [3:0] F_LT = 4'b1000;
  localparam logic [3:0] F_EQ = 4'b0110;
  localparam logic [3:0] F_GT = 4'b0010;
  localparam logic [3:0] F_UN = 4'b0001;
  localparam logic [3:0] F_UA = 4'b0011;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] op_a_i = '0;
  logic [31:0] op_b_i = '0;
  logic        negate_i = 1'b0;
  logic        signal_i = 1'b0;
  logic        alt_c_i = 1'b0;
  logic [3:0]  flags_o;
  logic        flags_vld_o;
  logic        inv_exc_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  fpcmp_nzcv dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .valid_i    (valid_i),
    .op_a_i     (op_a_i),
    .op_b_i     (op_b_i),
    .negate_i   (negate_i),
    .signal_i   (signal_i),
    .alt_c_i    (alt_c_i),
    .flags_o    (flags_o),
    .flags_vld_o(flags_vld_o),
    .inv_exc_o  (inv_exc_o)
  );

  task automatic check_out(input string req, input logic [3:0] exp_f,
                           input logic exp_v, input logic exp_x);
    checks++;
    if (flags_o !== exp_f || flags_vld_o !== exp_v || inv_exc_o !== exp_x) begin
      errors++;
      $display("FAIL %s: flags=%b vld=%b exc=%b expected flags=%b vld=%b exc=%b",
               req, flags_o, flags_vld_o, inv_exc_o, exp_f, exp_v, exp_x);
    end
  endtask

  // One strobe; result checked one edge later, then pulse end one cycle on.
  task automatic run_cmp(input string req, input logic [31:0] a, input logic [31:0] b,
                         input logic neg, input logic sig, input logic alt,
                         input logic [3:0] exp_f, input logic exp_x);
    @(negedge clk);
    op_a_i = a; op_b_i = b; negate_i = neg; signal_i = sig; alt_c_i = alt;
    valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
    check_out(req, exp_f, 1'b1, exp_x);
    @(negedge clk);
    check_out({req, " R11 pulse end"}, exp_f, 1'b0, 1'b0);
  endtask

  task automatic t_reset;
    #1;
    check_out("R1 during reset", 4'b0000, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    check_out("R1 still in reset", 4'b0000, 1'b0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check_out("R1 after release", 4'b0000, 1'b0, 1'b0);
  endtask

  task automatic t_ordered;
    run_cmp("R3 lt 1<2",      P_TWO, P_ONE, 0, 0, 0, F_LT, 0);
    run_cmp("R3 gt 2>1",      P_ONE, P_TWO, 0, 0, 0, F_GT, 0);
    run_cmp("R3 eq 1==1",     P_ONE, P_ONE, 0, 0, 0, F_EQ, 0);
    run_cmp("R3 lt -2<-1",    M_ONE, M_TWO, 0, 0, 0, F_LT, 0);
    run_cmp("R3 lt -1<2",     P_TWO, M_ONE, 0, 0, 0, F_LT, 0);
    run_cmp("R3 gt denorm>0", P_ZERO, DENORM, 0, 0, 0, F_GT, 0);
  endtask

  task automatic t_zero;
    run_cmp("R6 -0 vs +0", P_ZERO, M_ZERO, 0, 0, 0, F_EQ, 0);
    run_cmp("R6 +0 vs -0", M_ZERO, P_ZERO, 0, 0, 0, F_EQ, 0);
  endtask

  task automatic t_inf;
    run_cmp("R12 +inf==+inf", P_INF, P_INF, 0, 0, 0, F_EQ, 0);
    run_cmp("R12 -inf<max",   P_MAX, M_INF, 0, 0, 0, F_LT, 0);
    run_cmp("R12 +inf>max",   P_MAX, P_INF, 0, 0, 0, F_GT, 0);
  endtask

  task automatic t_unordered;
    run_cmp("R4 qnan in A",    QNAN, P_ONE, 0, 0, 0, F_UN, 0);
    run_cmp("R9 qnan in B",    P_ONE, QNAN, 0, 0, 0, F_UN, 0);
    run_cmp("R5 alt unord",    QNAN, P_ONE, 0, 0, 1, F_UA, 0);
    run_cmp("R5 alt ordered",  P_TWO, P_ONE, 0, 0, 1, F_LT, 0);
    run_cmp("R5 alt equal",    P_ONE, P_ONE, 0, 0, 1, F_EQ, 0);
  endtask

  task automatic t_exceptions;
    run_cmp("R8 signal qnan",     QNAN, P_ONE, 0, 1, 0, F_UN, 1);
    run_cmp("R8 signal alt",      P_ONE, QNAN, 0, 1, 1, F_UA, 1);
    run_cmp("R11 signal ordered", P_TWO, P_ONE, 0, 1, 0, F_LT, 0);
    run_cmp("R10 snan quiet",     P_ONE, SNAN, 0, 0, 0, F_UN, 1);
    run_cmp("R10 snan signal",    SNAN, P_ONE, 0, 1, 0, F_UN, 1);
  endtask

  task automatic t_negate;
    run_cmp("R7 -1 vs -(1)",  P_ONE, M_ONE, 1, 0, 0, F_EQ, 0);
    run_cmp("R7 1 vs -(-2)",  M_TWO, P_ONE, 1, 0, 0, F_LT, 0);
    run_cmp("R7 1 vs -(1)",   P_ONE, P_ONE, 1, 0, 0, F_GT, 0);
    run_cmp("R7 +0 vs -(+0)", P_ZERO, P_ZERO, 1, 0, 0, F_EQ, 0);
    run_cmp("R7 neg qnan",    QNAN, P_ONE, 1, 0, 0, F_UN, 0);
  endtask

  task automatic t_hold;
    run_cmp("R2 load gt", P_ONE, P_TWO, 0, 0, 0, F_GT, 0);
    @(negedge clk);
    op_a_i = SNAN; op_b_i = QNAN; signal_i = 1'b1; alt_c_i = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check_out("R2 hold without strobe", F_GT, 1'b0, 1'b0);
    op_a_i = P_TWO; op_b_i = M_ONE; signal_i = 1'b0; alt_c_i = 1'b0;
    @(negedge clk);
    check_out("R2 hold second change", F_GT, 1'b0, 1'b0);
  endtask

  initial begin
    t_reset();
    t_ordered();
    t_zero();
    t_inf();
    t_unordered();
    t_exceptions();
    t_negate();
    t_hold();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule